// File: doc/BRIEF.md
# Synchronous Burst SRAM With Strobe Decoding

This block models a synchronous burst static RAM together with the logic that decodes its control pins. On every rising clock edge it samples three chip enables, a processor address strobe, a controller address strobe, a burst-advance input and the write enables. It classifies each cycle as one of four kinds: a deselect, a burst start at the external address, a burst continuation at the next address, or a burst suspension that reuses the current address. It then reads a word or writes it with a byte mask.

The read path is flow-through. The address accepted at an edge selects the array word that the output shows for the rest of that clock cycle. An output enable gates the bus without passing through the clock. A sleep input floats the bus, and entering or leaving sleep each take two clock edges. The array is a small parameterised register file. Data in and data out are separate ports, and a drive flag stands in for the tri-state control of a shared bus.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, no burst is open. An advance-only cycle drives nothing, and `dq_oe` is 0.
- R2: A start is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe in any other enable state is a deselect. A deselect leaves `dq_oe` at 0, and advance cycles that follow it drive nothing.
- R3: While `ce1_n`=1, a low `adsp_n` is ignored. With `adsc_n` high, the cycle is treated as a continue or suspend of the open burst. With `adsc_n` low, the cycle is a deselect.
- R4: A selected cycle with `adsp_n`=0 loads `addr` and reads, whatever the values of `gw_n`, `bwe_n` and `bw_n`.
- R5: A selected cycle with `adsp_n`=1 and `adsc_n`=0 loads `addr`. It writes when the combined write is active and reads otherwise.
- R6: With both strobes inactive and a burst open, `adv_n`=0 advances the address and `adv_n`=1 reuses it. The address advances by incrementing bits [1:0] modulo 4, with the upper bits held. The cycle reads or writes according to the combined write.
- R7: The combined write is active when `gw_n`=0, or when `bwe_n`=0 and some `bw_n` bit is 0. When `gw_n`=0, all bytes are written. Otherwise only the bytes whose `bw_n` bit is 0 are written, where byte i is `wdata[8i+7:8i]`.
- R8: `dq_oe` is 1 only after a read cycle, and only while `oe_n`=0. `oe_n` acts combinationally within the cycle, and write cycles never drive the bus.
- R9: While `zz`=1, `dq_oe` is 0, every command is ignored, and any open burst is closed. After `zz` returns to 0, the commands at the next two edges are ignored and the third is accepted.
- R10: Read data for the address accepted at an edge is on `dq_out` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NBYTES | Per-byte write enables, active low |
| addr | input | AW | External word address |
| wdata | input | NBYTES*BYTE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| dq_out | output | NBYTES*BYTE_W | Read data |
| dq_oe | output | 1 | High when the data bus is driven |

## Verification
The bench writes a four-beat burst through the controller strobe and lets the fifth beat wrap onto the first word. It then reads the same words back through the processor strobe, with advance, suspend and wrap beats. This separates a correct modulo-4 counter from one that carries into the upper address bits. Byte-masked writes are followed by controller-strobe cycles whose byte enables are all high, and by cycles where only the byte enables are low. These show whether the combined write term requires both `bwe_n` and a byte enable. Deselects on each enable, processor strobes with `ce1_n` high, an output-enable toggle between edges, and a write burst issued during sleep recovery each give a different result if the gating order or the two-edge recovery count is wrong.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW     = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce1_n,
  input  logic                     ce2,
  input  logic                     ce3_n,
  input  logic                     adsp_n,
  input  logic                     adsc_n,
  input  logic                     adv_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [AW-1:0]            addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     oe_n,
  input  logic                     zz,
  output logic [NBYTES*BYTE_W-1:0] dq_out,
  output logic                     dq_oe
);
  localparam int DW    = NBYTES * BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    slp_cnt;
  logic          burst_on;
  logic          rd_q;
  logic [AW-1:0] addr_q;

  wire awake     = !zz && (slp_cnt == 2'd0);
  wire sel       = !ce1_n && ce2 && !ce3_n;
  wire p_strobe  = !adsp_n && !ce1_n;
  wire c_strobe  = !adsc_n && !p_strobe;
  wire any_wr    = !gw_n || (!bwe_n && !(&bw_n));
  wire start     = (p_strobe || c_strobe) && sel;
  wire deselect  = (p_strobe || c_strobe) && !sel;
  wire go_on     = !p_strobe && !c_strobe && burst_on;

  wire [AW-1:0] nxt_addr = {addr_q[AW-1:2], addr_q[1:0] + 2'd1};
  wire [AW-1:0] acc_addr = start ? addr : (adv_n ? addr_q : nxt_addr);

  wire do_wr = awake && ((start && c_strobe && any_wr) || (go_on && any_wr));
  wire do_rd = awake && ((start && !(c_strobe && any_wr)) || (go_on && !any_wr));
  wire [NBYTES-1:0] ben = gw_n ? ~bw_n : {NBYTES{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_cnt  <= 2'd0;
      burst_on <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
    end else if (zz) begin
      if (slp_cnt != 2'd2) slp_cnt <= slp_cnt + 2'd1;
      burst_on <= 1'b0;
      rd_q     <= 1'b0;
    end else if (slp_cnt != 2'd0) begin
      slp_cnt  <= slp_cnt - 2'd1;
      burst_on <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      rd_q <= do_rd;
      if (start) begin
        burst_on <= 1'b1;
        addr_q   <= addr;
      end else if (deselect) begin
        burst_on <= 1'b0;
      end else if (burst_on) begin
        addr_q <= acc_addr;
      end
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (do_wr && ben[b])
        mem[acc_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign dq_out = mem[addr_q];
  assign dq_oe  = rd_q && !oe_n && !zz;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ce1_n,
  input logic ce2,
  input logic ce3_n,
  input logic adsp_n,
  input logic adsc_n,
  input logic gw_n,
  input logic oe_n,
  input logic zz,
  input logic dq_oe
);
  // R5
  ctl_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n && !gw_n) |=> !dq_oe);

  // R3
  ce1_high_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && ce1_n) |=> !dq_oe);

  // R2
  proc_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !ce1_n && (!ce2 || ce3_n)) |=> !dq_oe);

  // R9
  sleep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !dq_oe);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zz) |=> !dq_oe);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n), .oe_n(oe_n), .zz(zz),
  .dq_oe(dq_oe)
);

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] dq_out;
  logic        dq_oe;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    bit          chk;
    bit          drv;
    logic [31:0] d;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .zz(zz), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic compare(input bit drv, input logic [31:0] d, input string tag);
    n_cmp++;
    if (drv) begin
      if (dq_oe !== 1'b1 || dq_out !== d) begin
        n_bad++;
        $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", tag, dq_oe, dq_out, d);
      end
    end else if (dq_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: oe=%b expected oe=0", tag, dq_oe);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) compare(it.drv, it.d, it.tag);
    end
  end

  task automatic tick(input bit drv, input logic [31:0] d, input string tag);
    item_t it;
    it.chk = 1; it.drv = drv; it.d = d; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; zz = 0; wdata = '0; addr = '0;
  endtask
  task automatic cwr(input logic [5:0] a, input logic [31:0] d);
    idle(); adsc_n = 0; addr = a; gw_n = 0; wdata = d;
  endtask
  task automatic pread(input logic [5:0] a);
    idle(); adsp_n = 0; addr = a;
  endtask
  task automatic cont_wr(input logic [31:0] d);
    idle(); adv_n = 0; gw_n = 0; wdata = d;
  endtask
  task automatic cont_rd();
    idle(); adv_n = 0;
  endtask

  localparam logic [31:0] A = 32'hA0A1A2A3, B = 32'hB0B1B2B3, C = 32'hC0C1C2C3,
                          D = 32'hD0D1D2D3, E = 32'hE0E1E2E3;

  initial begin
    idle();
    @(negedge clk);
    tick(0, 0, "R1 in reset");
    tick(0, 0, "R1 in reset");
    rst_n = 1;
    cont_rd();            tick(0, 0, "R1 advance after reset");

    cwr(6'd4, A);         tick(0, 0, "R5 write start");
    cont_wr(B);           tick(0, 0, "R8 write beat");
    cont_wr(C);           tick(0, 0, "R8 write beat");
    cont_wr(D);           tick(0, 0, "R8 write beat");
    cont_wr(E);           tick(0, 0, "R6 write wrap");

    pread(6'd5); gw_n = 0; bwe_n = 0; bw_n = 4'h0; wdata = 32'hFFFFFFFF;
                          tick(1, B, "R4 forced read");
    cont_rd();            tick(1, C, "R6 advance");
    idle();               tick(1, C, "R6 suspend");
    cont_rd();            tick(1, D, "R10 advance read");
    cont_rd();            tick(1, E, "R6 wrap read");
    idle(); oe_n = 1;     tick(0, 0, "R8 oe high");
    oe_n = 0; #1; compare(1, E, "R8 oe async low");
    oe_n = 1; #1; compare(0, 0, "R8 oe async high");

    cwr(6'd16, 32'h11223344);        tick(0, 0, "R5 full write");
    idle(); adsc_n = 0; addr = 6'd16; bwe_n = 0; bw_n = 4'b1010; wdata = 32'hAABBCCDD;
                                     tick(0, 0, "R7 byte write");
    idle(); adsc_n = 0; addr = 6'd16; bwe_n = 0;
                                     tick(1, 32'h11BB33DD, "R7 no byte enables");
    idle(); adsc_n = 0; addr = 6'd16; bw_n = 4'h0;
                                     tick(1, 32'h11BB33DD, "R7 bwe inactive");

    idle(); adsc_n = 0; addr = 6'd16; ce2 = 0; tick(0, 0, "R2 ce2 deselect");
    cont_rd();                        tick(0, 0, "R2 advance after deselect");
    pread(6'd16); ce3_n = 1;          tick(0, 0, "R2 ce3 deselect");

    pread(6'd5);                      tick(1, B, "R4 read start");
    idle(); ce1_n = 1; adsp_n = 0;    tick(1, B, "R3 adsp ignored");
    idle(); ce1_n = 1; adsc_n = 0;    tick(0, 0, "R3 adsc deselect");
    cont_rd();                        tick(0, 0, "R3 after deselect");

    cwr(6'd32, 32'hC0DE0000);         tick(0, 0, "R5 write");
    cont_wr(32'hC0DE0001);            tick(0, 0, "R6 write");
    cont_wr(32'hC0DE0002);            tick(0, 0, "R6 write");
    pread(6'd32);                     tick(1, 32'hC0DE0000, "R10 read");
    idle(); zz = 1;                   tick(0, 0, "R9 sleep");
    idle(); zz = 1;                   tick(0, 0, "R9 sleep");
    idle(); zz = 1; adsp_n = 0;       tick(0, 0, "R9 sleep ignores");
    cwr(6'd32, 32'h1);                tick(0, 0, "R9 recovery 1");
    cwr(6'd33, 32'h2);                tick(0, 0, "R9 recovery 2");
    cwr(6'd34, 32'h3);                tick(0, 0, "R9 accepted write");
    pread(6'd32);                     tick(1, 32'hC0DE0000, "R9 kept word 0");
    cont_rd();                        tick(1, 32'hC0DE0001, "R9 kept word 1");
    cont_rd();                        tick(1, 32'h3, "R9 new word 2");

    idle();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run incomplete, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule